// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Divider and Source Switcher

This block produces a processor clock from a fast on-chip reference. Software picks a power-of-two divide ratio, or asks for an external clock instead, by writing one control word through a single-cycle write port that runs on the reference clock. The divided clock is a register output, so its waveform never depends on combinational decoding of counter bits.

A new setting is not applied at once. The request waits through a two-step alignment chain on output-period boundaries. A new ratio is loaded only at the falling edge that ends a full output period. A move to or from the external clock goes through a break-before-make handshake. In that handshake each source is gated only while it is low, and each side waits for a two-flop synchronized confirmation from the other clock domain. A busy flag covers the whole sequence. A write that arrives while busy is held, and the most recent one is applied once the current switch completes.

Top module: `dcs_clk_switch`

## Requirements
- R1: `wr_data[3:0]` is a ratio code c. The divided output period is 2^min(MIN_EXP+c, MAX_EXP) reference periods, so codes beyond the top ratio clamp to 2^MAX_EXP.
- R2: When `wr_data[4]` is 1, the written setting routes `ext_clk` to `clk_out`, and the output period equals the external clock period.
- R3: While a switch is in progress, no high or low phase of `clk_out` is shorter than the shorter of the old and new half-periods.
- R4: The divided source and the external source are never enabled onto the output at the same time.
- R5: The divide ratio changes only at the falling edge of the divided clock, which ends a full output period.
- R6: `busy` is 1 in the cycle after a write and stays 1 until the new source drives the output. A change between two divided ratios clears `busy` within two old output periods plus four reference cycles.
- R7: A write accepted while `busy` is 1 is held and applied after the current switch. If several such writes arrive, only the last one takes effect.
- R8: After reset the block runs at the slowest divided ratio with the external clock deselected and `busy` at 0. `clk_out` stays low for the first full divided half-period.
- R9: The gate enable of the divided source changes only while the divided clock is low on both sides of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock; also clocks the write port |
| ext_clk | input | 1 | Optional external clock, asynchronous to the reference |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| wr_en | input | 1 | One-cycle write strobe for the control word |
| wr_data | input | CODE_W+1 | Bit CODE_W selects the external clock; bits CODE_W-1:0 hold the ratio code |
| clk_out | output | 1 | Processor clock |
| busy | output | 1 | 1 while a requested setting is not yet driving the output |

## Verification
The assertions check three things on every reference edge: that the two source enables are mutually exclusive, that the divided gate moves only inside a low stretch of the divided clock, and that the loaded ratio changes only at a period-ending falling edge. They also check that busy rises after every write and that the target exponent stays in its legal range. The bench covers what only whole waveforms can show. It confirms the resulting output periods for each ratio code, including clamped codes and the external path. It measures every output phase against the runt bound across a chain of switches. It also checks the switch latency, the replacement of queued writes by later ones, and the low first half-period after reset.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LOAD,
    ST_HANDOFF
  } sw_state_e;

  // Map a ratio code onto a divide exponent, saturating at the top ratio.
  function automatic int unsigned dcs_code_to_exp(input int unsigned code,
                                                  input int unsigned lo,
                                                  input int unsigned hi);
    int unsigned e;
    e = lo + code;
    return (e > hi) ? hi : e;
  endfunction

endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync #(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 2'b00;
        else         sync_q <= {sync_q[0], 1'b1};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 2'b00;
        else         sync_q <= {sync_q[0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dcs_ratio_div.sv
module dcs_ratio_div #(
  parameter int unsigned MIN_EXP = 4,
  parameter int unsigned MAX_EXP = 19,
  localparam int unsigned EXPW = $clog2(MAX_EXP + 1),
  localparam int unsigned CW   = MAX_EXP - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [EXPW-1:0] load_exp,
  output logic            div_clk,
  output logic            period_end,
  output logic            low_hold
);

  logic [CW-1:0]   hcnt_q, hcnt_d;
  logic [EXPW-1:0] exp_q, exp_d;
  logic            div_q, div_d;
  logic [CW:0]     one_sh;
  logic [CW-1:0]   hlast;
  logic            toggle;

  // Half-period length is 2^(exp-1) reference cycles.
  always_comb begin
    one_sh = (CW + 1)'(1) << (exp_q - EXPW'(1));
    hlast  = one_sh[CW-1:0] - CW'(1);
    toggle = (hcnt_q == hlast);
  end

  always_comb begin
    hcnt_d = hcnt_q + CW'(1);
    div_d  = div_q;
    exp_d  = exp_q;
    if (toggle) begin
      hcnt_d = '0;
      div_d  = ~div_q;
      if (div_q && load_en) exp_d = load_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      div_q  <= 1'b0;
      exp_q  <= EXPW'(MAX_EXP);
    end else begin
      hcnt_q <= hcnt_d;
      div_q  <= div_d;
      exp_q  <= exp_d;
    end
  end

  assign div_clk    = div_q;
  assign period_end = toggle & div_q;
  assign low_hold   = ~div_q & ~toggle;

  // R5
  ratio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q != $past(exp_q)) |-> ($past(div_q) && !div_q));

endmodule

// File: rtl/dcs_switch_ctrl.sv
module dcs_switch_ctrl #(
  parameter int unsigned MIN_EXP = 4,
  parameter int unsigned MAX_EXP = 19,
  parameter int unsigned CODE_W  = 4,
  localparam int unsigned EXPW = $clog2(MAX_EXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_ext,
  input  logic              period_end,
  input  logic              settled,
  output logic              load_en,
  output logic [EXPW-1:0]   load_exp,
  output logic              want_ext,
  output logic              busy
);

  import dcs_pkg::*;

  localparam logic [EXPW-1:0] EXP_LO = EXPW'(MIN_EXP);
  localparam logic [EXPW-1:0] EXP_HI = EXPW'(MAX_EXP);

  sw_state_e         state_q, state_d;
  logic [EXPW-1:0]   tgt_exp_q, tgt_exp_d;
  logic              tgt_ext_q, tgt_ext_d;
  logic              want_q, want_d;
  logic              hold_vld_q, hold_vld_d;
  logic [CODE_W-1:0] hold_code_q, hold_code_d;
  logic              hold_ext_q, hold_ext_d;
  logic              done;

  function automatic logic [EXPW-1:0] decode(input logic [CODE_W-1:0] c);
    return EXPW'(dcs_code_to_exp(32'(c), MIN_EXP, MAX_EXP));
  endfunction

  assign done = (state_q == ST_HANDOFF) && settled;

  always_comb begin
    state_d     = state_q;
    tgt_exp_d   = tgt_exp_q;
    tgt_ext_d   = tgt_ext_q;
    want_d      = want_q;
    hold_vld_d  = hold_vld_q;
    hold_code_d = hold_code_q;
    hold_ext_d  = hold_ext_q;
    load_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_en) begin
          tgt_exp_d = decode(wr_code);
          tgt_ext_d = wr_ext;
          state_d   = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (period_end) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        load_en = 1'b1;
        if (period_end) begin
          want_d  = tgt_ext_q;
          state_d = ST_HANDOFF;
        end
      end
      ST_HANDOFF: begin
        if (settled) begin
          if (wr_en) begin
            tgt_exp_d  = decode(wr_code);
            tgt_ext_d  = wr_ext;
            hold_vld_d = 1'b0;
            state_d    = ST_ALIGN;
          end else if (hold_vld_q) begin
            tgt_exp_d  = decode(hold_code_q);
            tgt_ext_d  = hold_ext_q;
            hold_vld_d = 1'b0;
            state_d    = ST_ALIGN;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (wr_en && (state_q != ST_IDLE) && !done) begin
      hold_vld_d  = 1'b1;
      hold_code_d = wr_code;
      hold_ext_d  = wr_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tgt_exp_q   <= EXP_HI;
      tgt_ext_q   <= 1'b0;
      want_q      <= 1'b0;
      hold_vld_q  <= 1'b0;
      hold_code_q <= '0;
      hold_ext_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      tgt_exp_q   <= tgt_exp_d;
      tgt_ext_q   <= tgt_ext_d;
      want_q      <= want_d;
      hold_vld_q  <= hold_vld_d;
      hold_code_q <= hold_code_d;
      hold_ext_q  <= hold_ext_d;
    end
  end

  assign load_exp = tgt_exp_q;
  assign want_ext = want_q;
  assign busy     = (state_q != ST_IDLE);

  // R6
  busy_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  // R1
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_exp_q >= EXP_LO) && (tgt_exp_q <= EXP_HI));

endmodule

// File: rtl/dcs_src_handoff.sv
module dcs_src_handoff (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic ext_clk,
  input  logic ext_rst_n,
  input  logic div_clk,
  input  logic div_low_hold,
  input  logic want_ext,
  output logic clk_out,
  output logic settled
);

  // Reference domain: divided-clock gate and view of the external gate.
  logic       en_div_q, en_div_d;
  logic [1:0] ext_on_sync_q;

  // External domain (falling edge): gate and views of the reference side.
  logic [1:0] want_sync_q;
  logic [1:0] div_on_sync_q;
  logic       en_ext_q, en_ext_d;

  always_comb begin
    en_div_d = en_div_q;
    if (div_low_hold) en_div_d = ~want_ext & ~ext_on_sync_q[1];
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      en_div_q      <= 1'b1;
      ext_on_sync_q <= 2'b00;
    end else begin
      en_div_q      <= en_div_d;
      ext_on_sync_q <= {ext_on_sync_q[0], en_ext_q};
    end
  end

  always_comb begin
    en_ext_d = want_sync_q[1] & ~div_on_sync_q[1];
  end

  always_ff @(negedge ext_clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      want_sync_q   <= 2'b00;
      div_on_sync_q <= 2'b11;
      en_ext_q      <= 1'b0;
    end else begin
      want_sync_q   <= {want_sync_q[0], want_ext};
      div_on_sync_q <= {div_on_sync_q[0], en_div_q};
      en_ext_q      <= en_ext_d;
    end
  end

  assign clk_out = (div_clk & en_div_q) | (ext_clk & en_ext_q);
  assign settled = want_ext ? (ext_on_sync_q[1] & ~en_div_q)
                            : (en_div_q & ~ext_on_sync_q[1]);

  // R4
  excl_src_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(en_div_q && en_ext_q));

  // R9
  div_gate_low_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (en_div_q != $past(en_div_q)) |-> (!div_clk && !$past(div_clk)));

endmodule

// File: rtl/dcs_clk_switch.sv
module dcs_clk_switch #(
  parameter int unsigned MIN_EXP = 4,
  parameter int unsigned MAX_EXP = 19,
  parameter int unsigned CODE_W  = 4,
  localparam int unsigned EXPW = $clog2(MAX_EXP + 1)
) (
  input  logic            ref_clk,
  input  logic            ext_clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CODE_W:0] wr_data,
  output logic            clk_out,
  output logic            busy
);

  logic            ref_rst_n;
  logic            ext_rst_n;
  logic            load_en;
  logic [EXPW-1:0] load_exp;
  logic            want_ext;
  logic            div_clk;
  logic            period_end;
  logic            low_hold;
  logic            settled;

  dcs_rst_sync #(.FALL_EDGE(1'b0)) u_ref_rst (
    .clk        (ref_clk),
    .arst_n     (rst_n),
    .rst_n_sync (ref_rst_n)
  );

  dcs_rst_sync #(.FALL_EDGE(1'b1)) u_ext_rst (
    .clk        (ext_clk),
    .arst_n     (rst_n),
    .rst_n_sync (ext_rst_n)
  );

  dcs_switch_ctrl #(
    .MIN_EXP (MIN_EXP),
    .MAX_EXP (MAX_EXP),
    .CODE_W  (CODE_W)
  ) u_ctrl (
    .clk        (ref_clk),
    .rst_n      (ref_rst_n),
    .wr_en      (wr_en),
    .wr_code    (wr_data[CODE_W-1:0]),
    .wr_ext     (wr_data[CODE_W]),
    .period_end (period_end),
    .settled    (settled),
    .load_en    (load_en),
    .load_exp   (load_exp),
    .want_ext   (want_ext),
    .busy       (busy)
  );

  dcs_ratio_div #(
    .MIN_EXP (MIN_EXP),
    .MAX_EXP (MAX_EXP)
  ) u_div (
    .clk        (ref_clk),
    .rst_n      (ref_rst_n),
    .load_en    (load_en),
    .load_exp   (load_exp),
    .div_clk    (div_clk),
    .period_end (period_end),
    .low_hold   (low_hold)
  );

  dcs_src_handoff u_handoff (
    .ref_clk      (ref_clk),
    .ref_rst_n    (ref_rst_n),
    .ext_clk      (ext_clk),
    .ext_rst_n    (ext_rst_n),
    .div_clk      (div_clk),
    .div_low_hold (low_hold),
    .want_ext     (want_ext),
    .clk_out      (clk_out),
    .settled      (settled)
  );

endmodule

// File: tb/dcs_clk_switch_tb_top.sv
`timescale 1ns/1ps
module dcs_clk_switch_tb_top;

  localparam real REF_P = 20.0;
  localparam real EXT_P = 46.0;
  localparam int  NV    = 7;
  // bit4 = external select, bits3:0 = ratio code (exp = min(4+code, 8))
  localparam logic [4:0] VEC_WR  [NV] = '{5'h00, 5'h02, 5'h09, 5'h11, 5'h01, 5'h1F, 5'h03};
  localparam real        VEC_PER [NV] = '{320.0, 1280.0, 5120.0, 46.0, 640.0, 46.0, 2560.0};

  logic       ref_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       wr_en   = 1'b0;
  logic [4:0] wr_data = '0;
  logic       clk_out;
  logic       busy;

  int  n_checks = 0;
  int  n_fail   = 0;
  real guard    = 2560.0;
  real last_edge;
  bit  have_last = 1'b0;
  bit  mon_on    = 1'b0;
  real cur_per   = 5120.0;
  bit  cur_ext   = 1'b0;

  always #(REF_P / 2.0) ref_clk = ~ref_clk;
  always #(EXT_P / 2.0) ext_clk = ~ext_clk;

  dcs_clk_switch #(.MIN_EXP(4), .MAX_EXP(8), .CODE_W(4)) dut_i (
    .ref_clk (ref_clk),
    .ext_clk (ext_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clk_out (clk_out),
    .busy    (busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  // Phase monitor (R3, R4, R9 at the ports): no runt high or low phase.
  always @(clk_out) begin
    if (mon_on && have_last) begin
      chk(($realtime - last_edge) >= guard - 0.5, "R3", "phase length",
          $realtime - last_edge, guard);
    end
    last_edge = $realtime;
    have_last = 1'b1;
  end

  task automatic do_write(input logic [4:0] d);
    @(negedge ref_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge ref_clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin
      @(negedge ref_clk);
      cyc++;
    end
  endtask

  task automatic measure(output real p);
    real t0;
    @(posedge clk_out);
    @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    p = $realtime - t0;
  endtask

  function automatic real min_r(input real a, input real b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    real p;
    real t_rel;
    int  cyc;
    // Reset state (R8)
    repeat (5) @(negedge ref_clk);
    rst_n = 1'b1;
    t_rel = $realtime;
    repeat (100) @(negedge ref_clk);
    chk(clk_out == 1'b0, "R8", "clk_out low in first half", real'(clk_out), 0.0);
    chk(busy == 1'b0, "R8", "busy after reset", real'(busy), 0.0);
    @(posedge clk_out);
    chk(($realtime - t_rel) >= 2560.0, "R8", "first rise time", $realtime - t_rel, 2560.0);
    mon_on = 1'b1;
    measure(p);
    chk((p > 5119.5) && (p < 5120.5), "R8", "slowest period", p, 5120.0);

    // Vector walk (R1, R2, R3, R6)
    for (int i = 0; i < NV; i++) begin
      real nper;
      bit  next_ext;
      nper     = VEC_PER[i];
      next_ext = VEC_WR[i][4];
      guard    = min_r(cur_per, nper) / 2.0;
      do_write(VEC_WR[i]);
      chk(busy == 1'b1, "R6", "busy after write", real'(busy), 1.0);
      wait_idle(cyc);
      if (!cur_ext && !next_ext) begin
        chk(real'(cyc) <= 2.0 * cur_per / REF_P + 4.0, "R6", "switch latency cycles",
            real'(cyc), 2.0 * cur_per / REF_P + 4.0);
      end
      measure(p);
      chk((p > nper - 0.5) && (p < nper + 0.5), next_ext ? "R2" : "R1",
          "output period", p, nper);
      guard   = nper / 2.0;
      cur_per = nper;
      cur_ext = next_ext;
    end

    // Held writes, latest wins (R7)
    guard = 160.0;
    do_write(5'h00);
    repeat (3) @(negedge ref_clk);
    do_write(5'h01);
    do_write(5'h02);
    chk(busy == 1'b1, "R7", "busy while queued", real'(busy), 1.0);
    wait_idle(cyc);
    measure(p);
    chk((p > 1279.5) && (p < 1280.5), "R7", "queued write result", p, 1280.0);
    chk(busy == 1'b0, "R7", "idle after queue", real'(busy), 0.0);

    // Clamped code from external back to slowest (R1, R2)
    guard = 23.0;
    do_write(5'h1A);
    wait_idle(cyc);
    measure(p);
    chk((p > 45.5) && (p < 46.5), "R2", "external period", p, 46.0);
    do_write(5'h0F);
    wait_idle(cyc);
    measure(p);
    chk((p > 5119.5) && (p < 5120.5), "R1", "clamped code period", p, 5120.0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule